// File: doc/BRIEF.md
# Extended-Precision NaN Propagation Selector

This block decides what an 80-bit extended-precision operation writes back when one or both of its operands is a NaN. Each operand arrives as a sign, a 15-bit exponent and a 64-bit significand whose top bit is the explicit integer bit. It also comes with a tag bit from the register file saying the operand belongs to the NaN class. The block sorts each operand into one of four groups: quiet NaN, signalling NaN, unsupported encoding, or not NaN-class. It then picks the result value and reports whether the destination is written, whether an invalid-operation exception is raised, and whether that exception is unmasked.

When both operands are NaNs, the one with the larger significand wins. If the two significands are equal, a default NaN supplied on its own input is used instead, whatever the signs. A masked invalid response always leaves a quiet NaN in the destination. An unmasked one leaves the destination alone and raises the unmasked flag, so the core can trap. A parameter puts one register stage on all outputs.

Top module: `nan_select`

## Requirements
- R1: An operand counts as a NaN only when its tag bit is 1, its exponent is all ones (0x7FFF) and significand bit 63 is 1. Such a NaN is quiet when significand bit 62 is 1 and signalling when bit 62 is 0.
- R2: A tagged operand that is not a NaN under R1 is unsupported. Any unsupported operand raises invalid. When invalid is masked (inv_mask_i = 1), the result is the constant quiet NaN: sign 1, exponent 0x7FFF, significand 0xC000_0000_0000_0000. When invalid is unmasked, write_en_o is 0 and unmasked_o is 1. Unsupported takes precedence over every NaN rule.
- R3: When both operands are NaNs with different significands, the operand whose 64-bit significand is larger as an unsigned number is selected, with its own sign.
- R4: When both operands are NaNs with equal significands, the default NaN input is selected, whatever the two signs.
- R5: When exactly one operand is a NaN and the other is untagged, that NaN is selected.
- R6: When no NaN operand is signalling, the selected value is written unchanged (write_en_o = 1) and invalid_o = 0.
- R7: When any NaN operand is signalling and invalid is masked, the selected value is written with significand bit 62 forced to 1, and invalid_o = 1, unmasked_o = 0.
- R8: When any NaN operand is signalling and invalid is unmasked, write_en_o = 0, invalid_o = 1 and unmasked_o = 1. Whenever write_en_o = 0, the result outputs carry operand a, the unchanged destination.
- R9: If the selected value has significand bit 63 equal to 0 (possible only for the default NaN input), the constant quiet NaN of R2 is used in its place.
- R10: When neither operand is tagged, write_en_o, invalid_o and unmasked_o are 0 and the result outputs carry operand a.
- R11: With OUT_REG = 1 (the default), every output reflects the inputs of the previous clock edge, and all outputs are 0 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_sign_i | input | 1 | Operand a (destination) sign |
| a_exp_i | input | 15 | Operand a exponent |
| a_sig_i | input | 64 | Operand a significand, bit 63 integer bit |
| a_tag_i | input | 1 | Operand a is tagged NaN-class |
| b_sign_i | input | 1 | Operand b sign |
| b_exp_i | input | 15 | Operand b exponent |
| b_sig_i | input | 64 | Operand b significand |
| b_tag_i | input | 1 | Operand b is tagged NaN-class |
| inv_mask_i | input | 1 | Invalid-operation exception masked |
| dflt_sign_i | input | 1 | Default NaN sign |
| dflt_exp_i | input | 15 | Default NaN exponent |
| dflt_sig_i | input | 64 | Default NaN significand |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | 15 | Result exponent |
| res_sig_o | output | 64 | Result significand |
| write_en_o | output | 1 | Destination should be updated |
| invalid_o | output | 1 | Invalid exception raised |
| unmasked_o | output | 1 | Raised invalid exception is unmasked |

## Verification
Two functions can land on the same cycle. First, an unsupported operand can sit beside a signalling NaN, and then the unsupported rule must win and the constant quiet NaN must appear instead of the quieted signalling one. Second, an equal-significand tie can coincide with a signalling operand, so the default NaN is both chosen and quieted. If that default also lacks its integer bit, it is replaced by the constant. Directed vectors build each overlap under both mask settings. Random vectors also copy one significand into the other a quarter of the time, so ties fall together with every mix of quiet, signalling and unsupported operands. Every case is judged against a bench model written from the requirements.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  localparam int IBIT = SIG_W - 1;
  localparam int QBIT = SIG_W - 2;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } xreal_t;

  typedef struct packed {
    xreal_t val;
    logic   wr;
    logic   inv;
    logic   unm;
  } sel_out_t;

  localparam xreal_t QNAN_C = '{sign: 1'b1, exp: {EXP_W{1'b1}},
                                sig: {2'b11, {(SIG_W-2){1'b0}}}};
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_sel_pkg::*;
(
  input  xreal_t op_i,
  input  logic   tag_i,
  output logic   is_nan_o,
  output logic   is_quiet_o,
  output logic   is_unsup_o
);
  logic enc_nan;
  assign enc_nan    = (&op_i.exp) & op_i.sig[IBIT];
  assign is_nan_o   = tag_i & enc_nan;
  assign is_quiet_o = tag_i & enc_nan & op_i.sig[QBIT];
  assign is_unsup_o = tag_i & ~enc_nan;
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_sel_pkg::*;
(
  input  xreal_t   a_i,
  input  xreal_t   b_i,
  input  xreal_t   dflt_i,
  input  logic     a_nan_i,
  input  logic     a_quiet_i,
  input  logic     b_nan_i,
  input  logic     b_quiet_i,
  input  logic     unsup_i,
  input  logic     mask_i,
  output sel_out_t out_o
);
  xreal_t pick;
  xreal_t pick_fix;
  logic   sig_any;

  always_comb begin
    pick    = a_i;
    sig_any = 1'b0;
    if (a_nan_i && b_nan_i) begin
      sig_any = ~(a_quiet_i & b_quiet_i);
      if (b_i.sig > a_i.sig)      pick = b_i;
      else if (b_i.sig == a_i.sig) pick = dflt_i;
      else                         pick = a_i;
    end else if (a_nan_i) begin
      sig_any = ~a_quiet_i;
      pick    = a_i;
    end else if (b_nan_i) begin
      sig_any = ~b_quiet_i;
      pick    = b_i;
    end
  end

  // pseudo-NaN (integer bit clear) replaced by the constant quiet NaN
  assign pick_fix = pick.sig[IBIT] ? pick : QNAN_C;

  always_comb begin
    out_o.val = a_i;
    out_o.wr  = 1'b0;
    out_o.inv = 1'b0;
    out_o.unm = 1'b0;
    if (unsup_i) begin
      out_o.inv = 1'b1;
      if (mask_i) begin
        out_o.wr  = 1'b1;
        out_o.val = QNAN_C;
      end else begin
        out_o.unm = 1'b1;
      end
    end else if (a_nan_i || b_nan_i) begin
      if (!sig_any) begin
        out_o.wr  = 1'b1;
        out_o.val = pick_fix;
      end else begin
        out_o.inv = 1'b1;
        if (mask_i) begin
          out_o.wr  = 1'b1;
          out_o.val = pick_fix;
          out_o.val.sig[QBIT] = 1'b1;
        end else begin
          out_o.unm = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nan_out_stage.sv
module nan_out_stage
  import nan_sel_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sel_out_t d_i,
  output sel_out_t q_o
);
  if (OUT_REG) begin : g_reg
    sel_out_t q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/nan_select.sv
module nan_select
  import nan_sel_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_sign_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [SIG_W-1:0] a_sig_i,
  input  logic             a_tag_i,
  input  logic             b_sign_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [SIG_W-1:0] b_sig_i,
  input  logic             b_tag_i,
  input  logic             inv_mask_i,
  input  logic             dflt_sign_i,
  input  logic [EXP_W-1:0] dflt_exp_i,
  input  logic [SIG_W-1:0] dflt_sig_i,
  output logic             res_sign_o,
  output logic [EXP_W-1:0] res_exp_o,
  output logic [SIG_W-1:0] res_sig_o,
  output logic             write_en_o,
  output logic             invalid_o,
  output logic             unmasked_o
);
  localparam int N_OP = 2;

  xreal_t   ops [N_OP];
  logic     tags[N_OP];
  logic     is_nan[N_OP], is_quiet[N_OP], is_unsup[N_OP];
  xreal_t   dflt;
  sel_out_t comb_out, reg_out;

  assign ops[0]  = '{sign: a_sign_i, exp: a_exp_i, sig: a_sig_i};
  assign ops[1]  = '{sign: b_sign_i, exp: b_exp_i, sig: b_sig_i};
  assign tags[0] = a_tag_i;
  assign tags[1] = b_tag_i;
  assign dflt    = '{sign: dflt_sign_i, exp: dflt_exp_i, sig: dflt_sig_i};

  for (genvar g = 0; g < N_OP; g++) begin : g_cls
    nan_classify u_cls (
      .op_i      (ops[g]),
      .tag_i     (tags[g]),
      .is_nan_o  (is_nan[g]),
      .is_quiet_o(is_quiet[g]),
      .is_unsup_o(is_unsup[g])
    );
  end

  nan_pick u_pick (
    .a_i      (ops[0]),
    .b_i      (ops[1]),
    .dflt_i   (dflt),
    .a_nan_i  (is_nan[0]),
    .a_quiet_i(is_quiet[0]),
    .b_nan_i  (is_nan[1]),
    .b_quiet_i(is_quiet[1]),
    .unsup_i  (is_unsup[0] | is_unsup[1]),
    .mask_i   (inv_mask_i),
    .out_o    (comb_out)
  );

  nan_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (comb_out),
    .q_o   (reg_out)
  );

  assign res_sign_o = reg_out.val.sign;
  assign res_exp_o  = reg_out.val.exp;
  assign res_sig_o  = reg_out.val.sig;
  assign write_en_o = reg_out.wr;
  assign invalid_o  = reg_out.inv;
  assign unmasked_o = reg_out.unm;

  // R8
  unmasked_blocks_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmasked_o |-> (invalid_o && !write_en_o));

  // R7
  masked_result_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_en_o && invalid_o) |-> (res_sig_o[QBIT] && res_sig_o[IBIT] && (&res_exp_o)));

  if (OUT_REG) begin : g_reg_chk
    // R10
    untagged_no_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!a_tag_i && !b_tag_i) |=> (!write_en_o && !invalid_o && !unmasked_o));

    // R2
    unsup_masked_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_tag_i && !((&a_exp_i) && a_sig_i[IBIT]) && inv_mask_i)
        |=> (write_en_o && invalid_o && res_sig_o == QNAN_C.sig && res_sign_o));
  end
endmodule

// File: tb/nan_select_test.sv
module nan_select_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_sign, b_sign, d_sign, a_tag, b_tag, mask;
  logic [14:0] a_exp, b_exp, d_exp;
  logic [63:0] a_sig, b_sig, d_sig;
  logic        r_sign, wr, inv, unm;
  logic [14:0] r_exp;
  logic [63:0] r_sig;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [63:0] QSIG = 64'hC000_0000_0000_0000;

  always #2.5 clk = ~clk;

  nan_select uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_sign_i(a_sign), .a_exp_i(a_exp), .a_sig_i(a_sig), .a_tag_i(a_tag),
    .b_sign_i(b_sign), .b_exp_i(b_exp), .b_sig_i(b_sig), .b_tag_i(b_tag),
    .inv_mask_i(mask),
    .dflt_sign_i(d_sign), .dflt_exp_i(d_exp), .dflt_sig_i(d_sig),
    .res_sign_o(r_sign), .res_exp_o(r_exp), .res_sig_o(r_sig),
    .write_en_o(wr), .invalid_o(inv), .unmasked_o(unm)
  );

  // expected {wr, inv, unm, sign, exp, sig}
  function automatic logic [82:0] model();
    bit an, bn, aq, bq, un, sg;
    logic [79:0] sel, av, bv, dv, q;
    av = {a_sign, a_exp, a_sig};
    bv = {b_sign, b_exp, b_sig};
    dv = {d_sign, d_exp, d_sig};
    q  = {1'b1, 15'h7FFF, QSIG};
    an = a_tag && a_exp == 15'h7FFF && a_sig[63];
    bn = b_tag && b_exp == 15'h7FFF && b_sig[63];
    aq = an && a_sig[62];
    bq = bn && b_sig[62];
    un = (a_tag && !an) || (b_tag && !bn);
    if (un) return mask ? {3'b110, q} : {3'b011, av};
    if (!an && !bn) return {3'b000, av};
    if (an && bn) begin
      sg  = !(aq && bq);
      sel = (b_sig > a_sig) ? bv : (b_sig == a_sig) ? dv : av;
    end else if (an) begin
      sg = !aq; sel = av;
    end else begin
      sg = !bq; sel = bv;
    end
    if (!sel[63]) sel = q;
    if (!sg) return {3'b100, sel};
    if (!mask) return {3'b011, av};
    sel[62] = 1'b1;
    return {3'b110, sel};
  endfunction

  task automatic check(input string req);
    logic [82:0] exp_v, act;
    exp_v = model();
    @(negedge clk);
    act = {wr, inv, unm, r_sign, r_exp, r_sig};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic set_a(input bit t, input logic s, input logic [14:0] e, input logic [63:0] m);
    a_tag = t; a_sign = s; a_exp = e; a_sig = m;
  endtask
  task automatic set_b(input bit t, input logic s, input logic [14:0] e, input logic [63:0] m);
    b_tag = t; b_sign = s; b_exp = e; b_sig = m;
  endtask

  // kind: 0 quiet, 1 signalling, 2 unsupported, 3 untagged
  task automatic gen(input int kind, output bit t, output logic s,
                     output logic [14:0] e, output logic [63:0] m);
    s = 1'($urandom);
    m = {$urandom, $urandom};
    e = 15'h7FFF;
    t = 1'b1;
    case (kind)
      0: m[63:62] = 2'b11;
      1: m[63:62] = 2'b10;
      2: if ($urandom % 2) m[63] = 1'b0; else e = 15'($urandom % 15'h7FFF);
      default: begin t = 1'b0; e = 15'($urandom); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    set_a(1, 0, 15'h7FFF, 64'hC000_0000_0000_0001);
    set_b(0, 0, 15'h3FFF, 64'h8000_0000_0000_0000);
    mask = 1; d_sign = 1; d_exp = 15'h7FFF; d_sig = QSIG;
    repeat (3) @(negedge clk);
    checks++;
    if ({wr, inv, unm, r_sign, r_exp, r_sig} !== '0) begin
      errors++;
      $display("FAIL R11 reset actual=%b%b%b %h expected=0", wr, inv, unm, r_sig);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet single NaN, R5 selected, R6 unchanged
    check("R1");
    set_a(0, 0, 15'h1234, 64'h8000_0000_0000_0000);
    set_b(1, 1, 15'h7FFF, 64'hE000_0000_0000_0005);
    check("R5");
    // R2: exponent all ones but integer bit clear
    set_a(1, 0, 15'h7FFF, 64'h4000_0000_0000_0000);
    mask = 1; check("R2");
    mask = 0; check("R2");
    // R2 dominates a signalling NaN in b
    set_b(1, 0, 15'h7FFF, 64'h8000_0000_0000_0001);
    mask = 1; check("R2");
    // R3: larger significand wins, both quiet
    set_a(1, 1, 15'h7FFF, 64'hC000_0000_0000_0010);
    set_b(1, 0, 15'h7FFF, 64'hC000_0000_0000_0020);
    check("R3");
    set_b(1, 0, 15'h7FFF, 64'hC000_0000_0000_0008);
    check("R3");
    // R4: tie, signs differ
    set_b(1, 0, 15'h7FFF, 64'hC000_0000_0000_0010);
    d_sign = 0; d_sig = 64'hC000_0000_0000_0777;
    check("R4");
    // R7: tie with signalling -> default quieted
    set_a(1, 1, 15'h7FFF, 64'h8000_0000_0000_0003);
    set_b(1, 0, 15'h7FFF, 64'h8000_0000_0000_0003);
    d_sig = 64'h8000_0000_0000_0777;
    mask = 1; check("R7");
    // R8: unmasked
    mask = 0; check("R8");
    // R9: default pseudo-NaN on a tie
    d_sig = 64'h4000_0000_0000_0001;
    mask = 1; check("R9");
    set_a(1, 0, 15'h7FFF, 64'hC000_0000_0000_0003);
    set_b(1, 1, 15'h7FFF, 64'hC000_0000_0000_0003);
    check("R9");
    d_sig = QSIG;
    // R10: neither tagged
    set_a(0, 0, 15'h7FFF, 64'hC000_0000_0000_0003);
    set_b(0, 1, 15'h7FFF, 64'h8000_0000_0000_0003);
    check("R10");
    // R6: single signalling masked and quiet passthrough
    set_b(1, 1, 15'h7FFF, 64'h8000_0000_0000_0009);
    check("R7");
    set_b(1, 1, 15'h7FFF, 64'hC000_0000_0000_0009);
    check("R6");

    for (int i = 0; i < 600; i++) begin
      bit t;
      logic s;
      logic [14:0] e;
      logic [63:0] m;
      gen(int'($urandom % 4), t, s, e, m); set_a(t, s, e, m);
      gen(int'($urandom % 4), t, s, e, m); set_b(t, s, e, m);
      if ($urandom % 4 == 0) b_sig[61:0] = a_sig[61:0];
      if ($urandom % 4 == 0) b_sig = a_sig;
      mask = 1'($urandom);
      d_sign = 1'($urandom);
      d_exp = 15'h7FFF;
      d_sig = {$urandom, $urandom};
      d_sig[62] = 1'($urandom);
      check("R3/R4/R6/R7/R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule